// File: doc/BRIEF.md
# Wait-State Bus Sizing Memory Interface

This block sits between a 32-bit CPU request port and a narrow external memory bus. The upper three address bits pick one of eight 2 MB slots: a 16-bit boot ROM, a 16-bit RAM, an internal configuration register block, and three 8-bit chip-select regions. The top two slots are unmapped. A 32-bit CPU access to a 16-bit region runs as two external cycles. An access to an 8-bit region runs as four byte cycles. Each external cycle is stretched by that region's programmable wait-state count.

The CPU holds its request stable until it sees a one-clock ready pulse. Read data is assembled from the narrow cycles and presented with that pulse. Writes to the boot ROM are blocked in hardware unless a flash write-enable bit is set in the ROM region's configuration word. A blocked write finishes at once on the CPU side, drives no external strobe and sets a sticky violation flag.

Top module: `memif_top`

## Requirements
- R1: The region is selected by address bits [23:21]: code 0 ROM (16-bit, ext_cs[0]), 1 RAM (16-bit, ext_cs[1]), 2 configuration registers, 3/4/5 the 8-bit regions on ext_cs[2]/ext_cs[3]/ext_cs[4]. Codes 6 and 7 are unmapped: ready comes one clock after the request with cpu_rdata 0 and no chip select.
- R2: An access to a 16-bit region runs two external cycles. The first is at the word address (address bits [1:0] forced to 0) and carries ext_be = cpu_be[1:0] and ext_wdata = cpu_wdata[15:0]. The second is at word address + 2 and carries cpu_be[3:2] and cpu_wdata[31:16]. Read halves fill cpu_rdata low half first.
- R3: An access to an 8-bit region runs four cycles at word address + 0, +1, +2, +3. Cycle k carries byte k of cpu_wdata on ext_wdata[7:0] (upper bits 0), ext_be = {0, cpu_be[k]}, and reads ext_rdata[7:0] into byte k of cpu_rdata.
- R4: Each external cycle holds ext_cs, ext_addr and its strobe for 1 + N clocks, where N is the region's 3-bit wait value. Counting the clock edge that accepts the request as edge 1, ready is high after edge beats*(1+N)+1.
- R5: cpu_ready is a single-clock pulse that follows the last external cycle. ext_oe is high during reads and ext_we during writes, only while a chip select is active.
- R6: Configuration word i sits at 0x400000 + 4*i. The order is i=0 ROM, 1 RAM, 2/3/4 the 8-bit regions on ext_cs[2..4]. Bits [2:0] hold the wait value, and bit 3 of word 0 is the flash write enable. A write takes effect only if cpu_be[0] is set. Words 5..7 read 0 and ignore writes. Register accesses complete with ready one clock after the request.
- R7: After reset every wait value is 7, flash write enable is 0, rom_violation is 0, and no chip select, strobe or ready is active.
- R8: A ROM write while flash write enable is 0 completes with ready one clock after the request. It drives no chip select or write strobe and leaves ROM contents unchanged. It sets rom_violation, which then stays set until reset.
- R9: A ROM write while flash write enable is 1 runs as a normal 16-bit write and changes ROM contents.
- R10: At most one ext_cs bit is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_be | input | 4 | CPU byte enables |
| cpu_rdata | output | 32 | Read data, valid with ready |
| cpu_ready | output | 1 | One-clock completion pulse |
| ext_cs | output | 5 | Active-high external chip selects |
| ext_addr | output | 24 | External byte address |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_be | output | 2 | External byte-lane enables |
| ext_oe | output | 1 | External read strobe |
| ext_we | output | 1 | External write strobe |
| rom_violation | output | 1 | Sticky blocked-ROM-write flag |

## Verification
The assertions assume that the CPU holds cpu_req, cpu_we, cpu_addr, cpu_wdata and cpu_be stable from the request until the ready pulse, and drops cpu_req in the clock that follows ready. The cycle-length check also assumes that the wait values do not change during an external access. That holds because register writes are only accepted while the sequencer is idle. The bench drives one access at a time from a task that raises the request, waits for ready and then lowers it, so back-to-back requests never overlap. Random addresses stay in the lowest 256 bytes of each region so that the bench memory can model every byte touched.

// File: rtl/memif_pkg.sv
package memif_pkg;

  localparam int ADDR_W  = 24;
  localparam int CPU_W   = 32;
  localparam int EXT_W   = 16;
  localparam int WS_W    = 3;
  localparam int N_EXT   = 5;
  localparam int SEL_LSB = 21;
  localparam int IDX_W   = 3;

  typedef logic [2:0] rcode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_DONE = 2'd2
  } seq_st_t;

  function automatic logic code_is_ext(rcode_t c);
    return (c == 3'd0) || (c == 3'd1) || (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
  endfunction

  function automatic logic code_is_csr(rcode_t c);
    return c == 3'd2;
  endfunction

  function automatic logic code_is_byte(rcode_t c);
    return (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
  endfunction

  function automatic logic [IDX_W-1:0] code_to_idx(rcode_t c);
    logic [IDX_W-1:0] r;
    case (c)
      3'd1:    r = IDX_W'(1);
      3'd3:    r = IDX_W'(2);
      3'd4:    r = IDX_W'(3);
      3'd5:    r = IDX_W'(4);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [1:0] last_beat(logic nb);
    return nb ? 2'd3 : 2'd1;
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(logic [ADDR_W-1:0] a, logic [1:0] beat, logic nb);
    logic [ADDR_W-1:0] base;
    base = {a[ADDR_W-1:2], 2'b00};
    if (nb) return base + ADDR_W'(beat);
    return base + ADDR_W'({beat, 1'b0});
  endfunction

  function automatic logic [1:0] beat_lanes(logic [3:0] be, logic [1:0] beat, logic nb);
    if (nb) return {1'b0, be[beat]};
    return beat[0] ? be[3:2] : be[1:0];
  endfunction

  function automatic logic [EXT_W-1:0] beat_wdata(logic [CPU_W-1:0] wd, logic [1:0] beat, logic nb);
    logic [EXT_W-1:0] r;
    if (nb) begin
      case (beat)
        2'd0:    r = {8'h00, wd[7:0]};
        2'd1:    r = {8'h00, wd[15:8]};
        2'd2:    r = {8'h00, wd[23:16]};
        default: r = {8'h00, wd[31:24]};
      endcase
    end else begin
      r = beat[0] ? wd[31:16] : wd[15:0];
    end
    return r;
  endfunction

  function automatic logic [CPU_W-1:0] merge_rd(logic [CPU_W-1:0] acc, logic [EXT_W-1:0] rd,
                                                logic [1:0] beat, logic nb);
    logic [CPU_W-1:0] r;
    r = acc;
    if (nb) begin
      case (beat)
        2'd0:    r[7:0]   = rd[7:0];
        2'd1:    r[15:8]  = rd[7:0];
        2'd2:    r[23:16] = rd[7:0];
        default: r[31:24] = rd[7:0];
      endcase
    end else if (beat[0]) begin
      r[31:16] = rd;
    end else begin
      r[15:0] = rd;
    end
    return r;
  endfunction

endpackage

// File: rtl/memif_decode.sv
module memif_decode
  import memif_pkg::*;
#(
  parameter int IDX_W_P = IDX_W
) (
  input  logic [2:0]         code,
  input  logic               we,
  input  logic               flash_we,
  output logic               is_ext,
  output logic               is_csr,
  output logic               is_byte,
  output logic [IDX_W_P-1:0] idx,
  output logic               rom_block
);

  always_comb begin
    is_ext    = code_is_ext(code);
    is_csr    = code_is_csr(code);
    is_byte   = code_is_byte(code);
    idx       = IDX_W_P'(code_to_idx(code));
    rom_block = (code == 3'd0) && we && !flash_we;
  end

endmodule

// File: rtl/memif_regfile.sv
module memif_regfile
  import memif_pkg::*;
#(
  parameter int N_EXT_P = N_EXT,
  parameter int WS_W_P  = WS_W,
  parameter int IDX_W_P = IDX_W,
  parameter int CPU_W_P = CPU_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W_P-1:0]        wr_idx,
  input  logic [WS_W_P:0]           wr_val,
  input  logic [IDX_W_P-1:0]        rd_idx,
  output logic [N_EXT_P*WS_W_P-1:0] ws_flat,
  output logic                      flash_we,
  output logic [CPU_W_P-1:0]        rd_word
);

  logic [WS_W_P-1:0] ws_q [N_EXT_P];
  logic              fwe_q;

  // wr_idx beyond the last region matches no register
  logic wr_out_of_range;
  assign wr_out_of_range = wr_en && (int'(wr_idx) >= N_EXT_P);

  genvar gi;
  generate
    for (gi = 0; gi < N_EXT_P; gi++) begin : g_ws
      always_ff @(posedge clk) begin
        if (!rst_n)
          ws_q[gi] <= '1;
        else if (wr_en && wr_idx == IDX_W_P'(gi))
          ws_q[gi] <= wr_val[WS_W_P-1:0];
      end
      assign ws_flat[gi*WS_W_P +: WS_W_P] = ws_q[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      fwe_q <= 1'b0;
    else if (wr_en && wr_idx == '0)
      fwe_q <= wr_val[WS_W_P];
  end

  assign flash_we = fwe_q;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_EXT_P; i++)
      if (rd_idx == IDX_W_P'(i)) rd_word[WS_W_P-1:0] = ws_q[i];
    if (rd_idx == '0) rd_word[WS_W_P] = fwe_q;
  end

  // R6: writes to unused configuration words leave every field unchanged
  assert_unused_word_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_of_range |=> ($stable(ws_flat) && $stable(flash_we)));

endmodule

// File: rtl/memif_seq.sv
module memif_seq
  import memif_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W,
  parameter int CPU_W_P  = CPU_W,
  parameter int EXT_W_P  = EXT_W,
  parameter int WS_W_P   = WS_W,
  parameter int IDX_W_P  = IDX_W,
  parameter int N_EXT_P  = N_EXT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                we,
  input  logic [ADDR_W_P-1:0] addr,
  input  logic [CPU_W_P-1:0]  wdata,
  input  logic [3:0]          be,
  input  logic                dec_is_ext,
  input  logic                dec_is_csr,
  input  logic                dec_is_byte,
  input  logic [IDX_W_P-1:0]  dec_idx,
  input  logic                dec_rom_block,
  input  logic [WS_W_P-1:0]   ws_sel,
  input  logic [CPU_W_P-1:0]  csr_rd,
  input  logic [EXT_W_P-1:0]  ext_rdata,
  output logic                accept,
  output logic                ready,
  output logic [CPU_W_P-1:0]  rdata,
  output logic [N_EXT_P-1:0]  ext_cs,
  output logic [ADDR_W_P-1:0] ext_addr,
  output logic [EXT_W_P-1:0]  ext_wdata,
  output logic [1:0]          ext_be,
  output logic                ext_oe,
  output logic                ext_we,
  output logic                rom_violation,
  output logic [WS_W_P-1:0]   beat_ws
);

  seq_st_t             st_q;
  logic [ADDR_W_P-1:0] a_q;
  logic                we_q;
  logic [CPU_W_P-1:0]  wd_q;
  logic [3:0]          be_q;
  logic                nb_q;
  logic [IDX_W_P-1:0]  idx_q;
  logic [WS_W_P-1:0]   ws_q;
  logic [WS_W_P-1:0]   wcnt_q;
  logic [1:0]          beat_q;
  logic [CPU_W_P-1:0]  acc_q;
  logic                viol_q;

  // named events for the checks
  logic beat_end;
  logic last_end;
  logic in_beat;

  assign accept   = (st_q == ST_IDLE) && req;
  assign in_beat  = (st_q == ST_BEAT);
  assign beat_end = in_beat && (wcnt_q == '0);
  assign last_end = beat_end && (beat_q == last_beat(nb_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      a_q    <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      be_q   <= '0;
      nb_q   <= 1'b0;
      idx_q  <= '0;
      ws_q   <= '0;
      wcnt_q <= '0;
      beat_q <= '0;
      acc_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req) begin
            a_q    <= addr;
            we_q   <= we;
            wd_q   <= wdata;
            be_q   <= be;
            nb_q   <= dec_is_byte;
            idx_q  <= dec_idx;
            ws_q   <= ws_sel;
            wcnt_q <= ws_sel;
            beat_q <= '0;
            acc_q  <= '0;
            if (dec_is_ext && !dec_rom_block) begin
              st_q <= ST_BEAT;
            end else begin
              st_q <= ST_DONE;
              if (dec_is_csr && !we) acc_q <= csr_rd;
              if (dec_rom_block) viol_q <= 1'b1;
            end
          end
        end
        ST_BEAT: begin
          if (wcnt_q == '0) begin
            if (!we_q) acc_q <= merge_rd(acc_q, ext_rdata, beat_q, nb_q);
            if (beat_q == last_beat(nb_q)) begin
              st_q <= ST_DONE;
            end else begin
              beat_q <= beat_q + 2'd1;
              wcnt_q <= ws_q;
            end
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ext_cs    = in_beat ? (N_EXT_P'(1) << idx_q) : '0;
    ext_addr  = beat_addr(a_q, beat_q, nb_q);
    ext_wdata = beat_wdata(wd_q, beat_q, nb_q);
    ext_be    = beat_lanes(be_q, beat_q, nb_q);
    ext_oe    = in_beat && !we_q;
    ext_we    = in_beat && we_q;
  end

  assign ready         = (st_q == ST_DONE);
  assign rdata         = acc_q;
  assign rom_violation = viol_q;
  assign beat_ws       = ws_q;

  // R5: the completion pulse lasts one clock
  assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R5: the last narrow cycle is followed directly by ready
  assert_ready_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_end |=> ready);

  // R8: the violation flag never clears without reset
  assert_violation_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_violation |=> rom_violation);

  // R10: never more than one chip select
  assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_cs));

  // R5: strobes only together with a chip select
  assert_strobe_with_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_oe || ext_we) |-> (ext_cs != '0));

endmodule

// File: rtl/memif_top.sv
module memif_top
  import memif_pkg::*;
#(
  parameter int ADDR_W_P  = ADDR_W,
  parameter int CPU_W_P   = CPU_W,
  parameter int EXT_W_P   = EXT_W,
  parameter int WS_W_P    = WS_W,
  parameter int N_EXT_P   = N_EXT,
  parameter int SEL_LSB_P = SEL_LSB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W_P-1:0] cpu_addr,
  input  logic [CPU_W_P-1:0]  cpu_wdata,
  input  logic [3:0]          cpu_be,
  output logic [CPU_W_P-1:0]  cpu_rdata,
  output logic                cpu_ready,
  output logic [N_EXT_P-1:0]  ext_cs,
  output logic [ADDR_W_P-1:0] ext_addr,
  output logic [EXT_W_P-1:0]  ext_wdata,
  input  logic [EXT_W_P-1:0]  ext_rdata,
  output logic [1:0]          ext_be,
  output logic                ext_oe,
  output logic                ext_we,
  output logic                rom_violation
);

  localparam int IDX_W_L = IDX_W;
  localparam int RUN_W   = WS_W_P + 1;

  logic [2:0]                code;
  logic                      dec_is_ext, dec_is_csr, dec_is_byte, dec_rom_block;
  logic [IDX_W_L-1:0]        dec_idx;
  logic [IDX_W_L-1:0]        reg_idx;
  logic [N_EXT_P*WS_W_P-1:0] ws_flat;
  logic                      flash_we;
  logic [CPU_W_P-1:0]        csr_rd;
  logic [WS_W_P-1:0]         ws_sel;
  logic                      accept;
  logic                      csr_wr;
  logic [WS_W_P-1:0]         beat_ws;

  assign code    = cpu_addr[SEL_LSB_P +: 3];
  assign reg_idx = cpu_addr[2 +: IDX_W_L];

  memif_decode #(.IDX_W_P(IDX_W_L)) u_dec (
    .code      (code),
    .we        (cpu_we),
    .flash_we  (flash_we),
    .is_ext    (dec_is_ext),
    .is_csr    (dec_is_csr),
    .is_byte   (dec_is_byte),
    .idx       (dec_idx),
    .rom_block (dec_rom_block)
  );

  assign csr_wr = accept && dec_is_csr && cpu_we && cpu_be[0];

  memif_regfile #(
    .N_EXT_P (N_EXT_P),
    .WS_W_P  (WS_W_P),
    .IDX_W_P (IDX_W_L),
    .CPU_W_P (CPU_W_P)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (csr_wr),
    .wr_idx   (reg_idx),
    .wr_val   (cpu_wdata[WS_W_P:0]),
    .rd_idx   (reg_idx),
    .ws_flat  (ws_flat),
    .flash_we (flash_we),
    .rd_word  (csr_rd)
  );

  always_comb begin
    ws_sel = '0;
    for (int i = 0; i < N_EXT_P; i++)
      if (dec_idx == IDX_W_L'(i)) ws_sel = ws_flat[i*WS_W_P +: WS_W_P];
  end

  memif_seq #(
    .ADDR_W_P (ADDR_W_P),
    .CPU_W_P  (CPU_W_P),
    .EXT_W_P  (EXT_W_P),
    .WS_W_P   (WS_W_P),
    .IDX_W_P  (IDX_W_L),
    .N_EXT_P  (N_EXT_P)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req           (cpu_req),
    .we            (cpu_we),
    .addr          (cpu_addr),
    .wdata         (cpu_wdata),
    .be            (cpu_be),
    .dec_is_ext    (dec_is_ext),
    .dec_is_csr    (dec_is_csr),
    .dec_is_byte   (dec_is_byte),
    .dec_idx       (dec_idx),
    .dec_rom_block (dec_rom_block),
    .ws_sel        (ws_sel),
    .csr_rd        (csr_rd),
    .ext_rdata     (ext_rdata),
    .accept        (accept),
    .ready         (cpu_ready),
    .rdata         (cpu_rdata),
    .ext_cs        (ext_cs),
    .ext_addr      (ext_addr),
    .ext_wdata     (ext_wdata),
    .ext_be        (ext_be),
    .ext_oe        (ext_oe),
    .ext_we        (ext_we),
    .rom_violation (rom_violation),
    .beat_ws       (beat_ws)
  );

  // run-length tracking of each external cycle, observed at the pins
  logic [RUN_W-1:0]    run_cnt_q;
  logic                prev_act_q;
  logic [ADDR_W_P-1:0] prev_addr_q;
  logic                cs_act;
  logic                run_end;

  assign cs_act  = (ext_cs != '0);
  assign run_end = prev_act_q && (!cs_act || ext_addr != prev_addr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt_q   <= '0;
      prev_act_q  <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_act_q  <= cs_act;
      prev_addr_q <= ext_addr;
      if (cs_act && prev_act_q && ext_addr == prev_addr_q)
        run_cnt_q <= run_cnt_q + 1'b1;
      else
        run_cnt_q <= cs_act ? RUN_W'(1) : '0;
    end
  end

  // R4: every external cycle lasts exactly one plus its wait count
  assert_cycle_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_end |-> (run_cnt_q == ({1'b0, beat_ws} + RUN_W'(1))));

  // R8: no write strobe reaches the ROM while writes to it are disabled
  assert_rom_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_we && ext_cs[0]) |-> flash_we);

endmodule

// File: tb/tb_memif_top.sv
module tb_memif_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic [4:0]  ext_cs;
  logic [23:0] ext_addr;
  logic [15:0] ext_wdata;
  logic [15:0] ext_rdata;
  logic [1:0]  ext_be;
  logic        ext_oe, ext_we;
  logic        rom_violation;

  always #10 clk = ~clk;

  memif_top dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .ext_cs(ext_cs), .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .ext_be(ext_be), .ext_oe(ext_oe), .ext_we(ext_we), .rom_violation(rom_violation)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // ---------- bench functions ----------
  function automatic int cs_to_idx(logic [4:0] cs);
    for (int i = 0; i < 5; i++) if (cs[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] seed_byte(int r, int j);
    return 8'((r * 53 + j * 29 + 7) & 255);
  endfunction

  function automatic logic [2:0] region_code(int idx);
    return (idx < 2) ? 3'(idx) : 3'(idx + 1);
  endfunction

  function automatic int beats_of(int idx);
    return (idx >= 2) ? 4 : 2;
  endfunction

  // ---------- external memory model ----------
  logic [7:0] mem [5][256];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 5; r++)
        for (int j = 0; j < 256; j++) mem[r][j] = seed_byte(r, j);
    end else if (ext_we && ext_cs != 0) begin
      int ri;
      ri = cs_to_idx(ext_cs);
      if (ri >= 2) begin
        if (ext_be[0]) mem[ri][ext_addr[7:0]] = ext_wdata[7:0];
      end else begin
        if (ext_be[0]) mem[ri][ext_addr[7:0]] = ext_wdata[7:0];
        if (ext_be[1]) mem[ri][8'(ext_addr[7:0] + 8'd1)] = ext_wdata[15:8];
      end
    end
  end

  always_comb begin
    int ri;
    ext_rdata = '0;
    ri = cs_to_idx(ext_cs);
    if (ri >= 2)
      ext_rdata = {8'h00, mem[ri][ext_addr[7:0]]};
    else if (ri >= 0)
      ext_rdata = {mem[ri][8'(ext_addr[7:0] + 8'd1)], mem[ri][ext_addr[7:0]]};
  end

  // ---------- expected state ----------
  logic [7:0] exp_mem [5][256];
  int         exp_ws [5];
  bit         exp_fwe;

  // ---------- per-access log ----------
  int          lg_n;
  logic [23:0] lg_addr [8];
  int          lg_len [8];
  int          lg_cs [8];
  logic [15:0] lg_wd [8];
  logic [1:0]  lg_be [8];
  bit          lg_we [8];
  bit          lg_oe [8];
  int          acc_lat;
  logic [31:0] acc_rd;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_access(input logic [23:0] a, input bit we, input logic [31:0] wd, input logic [3:0] be);
    lg_n = 0;
    acc_lat = 0;
    cpu_addr = a; cpu_we = we; cpu_wdata = wd; cpu_be = be; cpu_req = 1'b1;
    do begin
      @(negedge clk);
      acc_lat++;
      if (ext_cs != 0) begin
        if (lg_n == 0 || ext_addr != lg_addr[lg_n-1]) begin
          if (lg_n < 8) begin
            lg_addr[lg_n] = ext_addr; lg_len[lg_n] = 1; lg_cs[lg_n] = cs_to_idx(ext_cs);
            lg_wd[lg_n] = ext_wdata; lg_be[lg_n] = ext_be; lg_we[lg_n] = ext_we; lg_oe[lg_n] = ext_oe;
          end
          lg_n++;
        end else if (lg_n <= 8) begin
          lg_len[lg_n-1]++;
        end
      end
    end while (!cpu_ready && acc_lat < 200);
    acc_rd = cpu_rdata;
    cpu_req = 1'b0;
    @(negedge clk);
    chk(!cpu_ready, "R5 ready pulse width", 32'(cpu_ready), 0);
  endtask

  // configuration register access; checks latency 1
  task automatic csr_write(input int i, input logic [31:0] v, input logic [3:0] be);
    cpu_access(24'h400000 + 24'(i * 4), 1'b1, v, be);
    chk(acc_lat == 1 && lg_n == 0, "R6 register write latency", 32'(acc_lat), 1);
    if (be[0] && i < 5) begin
      exp_ws[i] = int'(v[2:0]);
      if (i == 0) exp_fwe = v[3];
    end
  endtask

  task automatic csr_read_check(input int i, input string tag);
    logic [31:0] e;
    cpu_access(24'h400000 + 24'(i * 4), 1'b0, 32'h0, 4'hF);
    e = 0;
    if (i < 5) e[2:0] = 3'(exp_ws[i]);
    if (i == 0) e[3] = exp_fwe;
    chk(acc_rd == e, tag, acc_rd, e);
    chk(acc_lat == 1, {tag, " latency"}, 32'(acc_lat), 1);
  endtask

  // external access with full expected-value check
  task automatic ext_check(input int idx, input logic [7:0] off, input bit we,
                           input logic [31:0] wd, input logic [3:0] be);
    logic [23:0] a;
    logic [7:0]  base;
    int nbt, step, ws;
    bit blocked, ok;
    string tg;
    logic [31:0] e;
    a = {region_code(idx), 13'h0, off};
    base = {off[7:2], 2'b00};
    nbt = beats_of(idx);
    step = (idx >= 2) ? 1 : 2;
    ws = exp_ws[idx];
    blocked = (idx == 0) && we && !exp_fwe;
    tg = (idx >= 2) ? "R3" : "R2";
    cpu_access(a, we, wd, be);
    if (blocked) begin
      chk(acc_lat == 1, "R8 blocked write latency", 32'(acc_lat), 1);
      chk(lg_n == 0, "R8 blocked write drives no cycle", 32'(lg_n), 0);
      chk(rom_violation == 1'b1, "R8 violation set", 32'(rom_violation), 1);
      return;
    end
    chk(acc_lat == nbt * (1 + ws) + 1, "R4 latency", 32'(acc_lat), 32'(nbt * (1 + ws) + 1));
    chk(lg_n == nbt, {tg, " cycle count"}, 32'(lg_n), 32'(nbt));
    if (lg_n == nbt) begin
      ok = 1;
      for (int k = 0; k < nbt; k++) begin
        logic [15:0] ewd;
        logic [1:0]  ebe;
        if (step == 1) begin
          ewd = {8'h00, wd[8*k +: 8]};
          ebe = {1'b0, be[k]};
        end else begin
          ewd = wd[16*k +: 16];
          ebe = be[2*k +: 2];
        end
        if (lg_addr[k] != a[23:0] - 24'(off) + 24'(base) + 24'(k * step)) ok = 0;
        if (lg_cs[k] != idx) ok = 0;
        if (lg_len[k] != 1 + ws) ok = 0;
        if (lg_be[k] != ebe) ok = 0;
        if (lg_we[k] != we || lg_oe[k] == we) ok = 0;
        if (we && lg_wd[k] != ewd) ok = 0;
      end
      chk(ok, {tg, " cycle sequence"}, lg_addr[0], a);
    end
    if (we) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) exp_mem[idx][8'(base + 8'(b))] = wd[8*b +: 8];
    end else begin
      for (int b = 0; b < 4; b++) e[8*b +: 8] = exp_mem[idx][8'(base + 8'(b))];
      chk(acc_rd == e, {tg, " read data"}, acc_rd, e);
    end
  endtask

  // ---------- watchdog ----------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------- main ----------
  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 5; r++) begin
      exp_ws[r] = 7;
      for (int j = 0; j < 256; j++) exp_mem[r][j] = seed_byte(r, j);
    end
    exp_fwe = 0;

    repeat (3) @(negedge clk);
    chk(ext_cs == 0 && !cpu_ready && !ext_we && !ext_oe, "R7 outputs idle in reset",
        {ext_cs, 2'b0, cpu_ready, ext_we, ext_oe}, 0);
    chk(!rom_violation, "R7 violation clear in reset", 32'(rom_violation), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // reset values of the configuration words
    for (int i = 0; i < 5; i++) csr_read_check(i, "R7 reset wait value");

    // default wait of 7 on RAM and on a byte region
    ext_check(1, 8'h10, 1'b0, 0, 4'hF);
    ext_check(3, 8'h20, 1'b0, 0, 4'hF);

    // unused words read 0, writes there ignored
    csr_read_check(5, "R6 unused word reads zero");
    csr_write(6, 32'h0, 4'hF);
    for (int i = 0; i < 5; i++) csr_read_check(i, "R6 unused write ignored");

    // byte enable 0 blocks a register write
    csr_write(1, 32'h2, 4'hE);
    csr_read_check(1, "R6 write without lane 0");

    // wait 0 and mixed waits
    csr_write(1, 32'h0, 4'h1);
    csr_write(2, 32'h0, 4'h1);
    csr_write(3, 32'h3, 4'h1);
    csr_write(4, 32'h5, 4'h1);
    csr_read_check(3, "R6 read back");
    ext_check(1, 8'h00, 1'b1, 32'hA1B2C3D4, 4'hF);
    ext_check(1, 8'h00, 1'b0, 0, 4'hF);
    ext_check(2, 8'h40, 1'b1, 32'h11223344, 4'hF);
    ext_check(2, 8'h40, 1'b0, 0, 4'hF);
    ext_check(3, 8'h44, 1'b1, 32'hDEADBEEF, 4'h5);
    ext_check(3, 8'h44, 1'b0, 0, 4'hF);
    ext_check(4, 8'hFC, 1'b1, 32'h0BADF00D, 4'hA);
    ext_check(4, 8'hFC, 1'b0, 0, 4'hF);
    ext_check(1, 8'h86, 1'b1, 32'h55667788, 4'hC);
    ext_check(1, 8'h84, 1'b0, 0, 4'hF);

    // R8: blocked ROM write, contents unchanged
    csr_write(0, 32'h2, 4'h1);
    ext_check(0, 8'h08, 1'b1, 32'hFFFFFFFF, 4'hF);
    ext_check(0, 8'h08, 1'b0, 0, 4'hF);

    // R1: unmapped slots
    cpu_access(24'hC00010, 1'b0, 0, 4'hF);
    chk(acc_rd == 0 && acc_lat == 1 && lg_n == 0, "R1 unmapped read", acc_rd, 0);
    cpu_access(24'hE00000, 1'b1, 32'h12345678, 4'hF);
    chk(acc_lat == 1 && lg_n == 0, "R1 unmapped write", 32'(lg_n), 0);

    // R9: enable flash writes
    csr_write(0, 32'h9, 4'h1);
    csr_read_check(0, "R9 flash enable read back");
    ext_check(0, 8'h08, 1'b1, 32'hCAFEF00D, 4'hF);
    ext_check(0, 8'h08, 1'b0, 0, 4'hF);
    chk(rom_violation, "R8 violation sticky", 32'(rom_violation), 1);

    // random mix
    for (int k = 0; k < 220; k++) begin
      int sel;
      sel = int'($urandom % 9);
      if (sel == 8) begin
        int ri;
        logic [31:0] v;
        ri = int'($urandom % 5);
        v = $urandom & 32'hF;
        csr_write(ri, v, 4'h1);
      end else begin
        int ri;
        logic [3:0] be;
        ri = int'($urandom % 5);
        be = 4'($urandom % 15) + 4'd1;
        ext_check(ri, 8'(($urandom % 64) * 4), 1'($urandom % 2), $urandom, be);
      end
    end

    // final read back of every modelled word
    for (int r = 0; r < 5; r++)
      for (int j = 0; j < 4; j++) ext_check(r, 8'(j * 4), 1'b0, 0, 4'hF);
    chk(rom_violation, "R8 violation held to the end", 32'(rom_violation), 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule